// File: doc/BRIEF.md
# ADC Sample Stream Serializer

This block takes a strobed stream of 10-bit converter samples and sends it out on a serial link made of a bit clock, a data line and an active-low chip select. The bit clock is made by dividing the system clock. The link needs no input from the receiving side.

Two framings are supported. In raw mode every sample becomes its own 10-bit frame, which finishes well inside one sample period. In packed mode the sample bits are laid end to end into 16-bit words, so eight samples fill exactly five words. A sample may straddle two words. A small bit buffer sits between the sample input and the shifter. It absorbs the uneven rate at which words fill up, and it drops a sample and raises a sticky flag when it has no room.

A mode change is applied only between groups. If packed mode is left partway through a group of eight, the group is closed by appending zero bits up to the next word boundary. The new mode starts once everything already buffered has left the shifter.

Top module: `adc_stream_ser`

## Requirements
- R1: After a synchronous reset, cs_n is 1, sclk is 0, mosi is 0 and overflow is 0. The buffer is empty, and the active mode is raw until the first group boundary.
- R2: With pack_mode = 0 (raw), each accepted sample is sent as one frame of exactly 10 bits, MSB first, with cs_n low for the whole frame.
- R3: In raw mode with default parameters, the frame for a sample has ended (cs_n back at 1) within 190 system clocks of the cycle in which the sample was strobed.
- R4: With pack_mode = 1 (packed), eight consecutive samples produce exactly five frames of 16 bits each.
- R5: In packed mode, the received bit sequence is the samples' bits concatenated in arrival order, each sample MSB first, with no gaps, and words split samples where needed.
- R6: mosi changes only while sclk is low, and it holds its value across every rising edge of sclk. sclk stays high for HALF_CYC clocks and low for at least HALF_CYC clocks inside a frame.
- R7: sclk is 0 whenever cs_n is 1. cs_n rises only with sclk low. Between two frames cs_n stays high for at least GAP_CYC system clocks.
- R8: A change of pack_mode from 1 to 0 partway through a group closes that group with zero bits up to the next 16-bit boundary (3 samples give 30 data bits plus 2 zeros). Later samples go out as raw frames.
- R9: A sample strobed while fewer than 10 bits of buffer space are free is dropped and sets overflow. overflow then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | SAMPLE_W | Sample value, taken when smp_valid is 1 |
| pack_mode | input | 1 | Requested framing: 1 packed, 0 raw |
| sclk | output | 1 | Serial bit clock, idle low |
| mosi | output | 1 | Serial data, MSB first |
| cs_n | output | 1 | Active-low frame select |
| overflow | output | 1 | Sticky flag for a dropped sample |

## Verification
The properties assume that reset is held from time zero until the first clock edges have passed. They assume smp_valid is a clean synchronous strobe, so the rise of the overflow flag can always be traced to a strobe one cycle earlier. The stimulus drives every input on the falling clock edge and holds reset from the first instant. It keeps samples 200 clocks apart in every scenario except the overflow one, where eight back-to-back strobes are used on purpose. It changes pack_mode only in quiet cycles without a strobe.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_LOW,
    ENG_HIGH,
    ENG_GAP
  } eng_state_t;

  typedef enum logic {
    MODE_RAW    = 1'b0,
    MODE_PACKED = 1'b1
  } ser_mode_t;

  // Zero bits needed to close a partial packed group of 'count' samples
  function automatic int pad_for(input int count, input int sample_w, input int word_w);
    int used;
    used = count * sample_w;
    return (word_w - (used % word_w)) % word_w;
  endfunction

endpackage

// File: rtl/adc_ser_bitbuf.sv
module adc_ser_bitbuf #(
  parameter int SAMPLE_W = 10,
  parameter int WORD_W   = 16,
  parameter int BUF_W    = 32,
  parameter int FILL_W   = $clog2(BUF_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  logic [SAMPLE_W-1:0] push_data,
  input  logic                pad_go,
  input  logic [FILL_W-1:0]   pad_len,
  input  logic                pop,
  input  logic [FILL_W-1:0]   pop_len,
  output logic [WORD_W-1:0]   buf_top,
  output logic [FILL_W-1:0]   fill,
  output logic [FILL_W-1:0]   free_bits
);

  localparam logic [FILL_W-1:0] CAP = FILL_W'(BUF_W);

  logic [BUF_W-1:0]  bits_q, bits_d, shifted, ext;
  logic [FILL_W-1:0] fill_q, fill_d, pop_amt, fill_base;

  // Oldest bit at the MSB; everything past fill_q is kept at zero
  always_comb begin
    pop_amt   = pop ? pop_len : '0;
    shifted   = bits_q << pop_amt;
    fill_base = fill_q - pop_amt;
    ext       = {push_data, {(BUF_W - SAMPLE_W){1'b0}}} >> fill_base;
    bits_d    = shifted;
    fill_d    = fill_base;
    if (push) begin
      bits_d = shifted | ext;
      fill_d = fill_base + FILL_W'(SAMPLE_W);
    end else if (pad_go) begin
      fill_d = fill_base + pad_len;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
      fill_q <= '0;
    end else begin
      bits_q <= bits_d;
      fill_q <= fill_d;
    end
  end

  assign buf_top   = bits_q[BUF_W-1 -: WORD_W];
  assign fill      = fill_q;
  assign free_bits = CAP - fill_base;

endmodule

// File: rtl/adc_ser_modectl.sv
module adc_ser_modectl
  import adc_ser_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int WORD_W   = 16,
  parameter int GROUP_N  = 8,
  parameter int FILL_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_req,
  input  logic              smp_valid,
  input  logic              accept,
  input  logic [FILL_W-1:0] free_bits,
  input  logic              fill_zero,
  output ser_mode_t         mode_act,
  output logic              pad_go,
  output logic [FILL_W-1:0] pad_len
);

  localparam int CNT_W = (GROUP_N > 1) ? $clog2(GROUP_N) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUP_N - 1);

  ser_mode_t        mode_q;
  logic [CNT_W-1:0] count_q;
  logic             pend, switch_now;

  always_comb begin
    pad_len    = FILL_W'(pad_for(int'(count_q), SAMPLE_W, WORD_W));
    pend       = (mode_req != logic'(mode_q));
    pad_go     = pend && (mode_q == MODE_PACKED) && (count_q != '0)
                 && !smp_valid && (free_bits >= pad_len);
    switch_now = pend && (count_q == '0) && fill_zero && !smp_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_RAW;
      count_q <= '0;
    end else begin
      if (pad_go) begin
        count_q <= '0;
      end else if (accept && mode_q == MODE_PACKED) begin
        count_q <= (count_q == LAST) ? '0 : count_q + 1'b1;
      end
      if (switch_now) begin
        mode_q <= ser_mode_t'(mode_req);
      end
    end
  end

  assign mode_act = mode_q;

endmodule

// File: rtl/adc_ser_shifter.sv
module adc_ser_shifter
  import adc_ser_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int WORD_W   = 16,
  parameter int HALF_CYC = 4,
  parameter int GAP_CYC  = 8,
  parameter int FILL_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  ser_mode_t         mode_act,
  input  logic [FILL_W-1:0] fill,
  input  logic [WORD_W-1:0] buf_top,
  output logic              pop,
  output logic [FILL_W-1:0] pop_len,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n
);

  localparam int TMAX  = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
  localparam int TMR_W = $clog2(TMAX + 1);
  localparam int BL_W  = $clog2(WORD_W + 1);
  localparam logic [TMR_W-1:0] HALF_LD = TMR_W'(HALF_CYC - 1);
  localparam logic [TMR_W-1:0] GAP_LD  = TMR_W'(GAP_CYC - 1);

  eng_state_t        state_q;
  logic [WORD_W-1:0] shreg_q;
  logic [BL_W-1:0]   left_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [FILL_W-1:0] chunk_len;

  always_comb begin
    chunk_len = (mode_act == MODE_PACKED) ? FILL_W'(WORD_W) : FILL_W'(SAMPLE_W);
    pop       = (state_q == ENG_IDLE) && (fill >= chunk_len);
    pop_len   = chunk_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      shreg_q <= '0;
      left_q  <= '0;
      tmr_q   <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      cs_n    <= 1'b1;
    end else begin
      unique case (state_q)
        ENG_IDLE: begin
          if (pop) begin
            mosi    <= buf_top[WORD_W-1];
            shreg_q <= buf_top << 1;
            left_q  <= BL_W'(chunk_len);
            cs_n    <= 1'b0;
            tmr_q   <= HALF_LD;
            state_q <= ENG_LOW;
          end
        end
        ENG_LOW: begin
          if (tmr_q == '0) begin
            sclk    <= 1'b1;
            tmr_q   <= HALF_LD;
            state_q <= ENG_HIGH;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ENG_HIGH: begin
          if (tmr_q == '0) begin
            sclk <= 1'b0;
            if (left_q == BL_W'(1)) begin
              cs_n    <= 1'b1;
              mosi    <= 1'b0;
              tmr_q   <= GAP_LD;
              state_q <= ENG_GAP;
            end else begin
              mosi    <= shreg_q[WORD_W-1];
              shreg_q <= shreg_q << 1;
              left_q  <= left_q - 1'b1;
              tmr_q   <= HALF_LD;
              state_q <= ENG_LOW;
            end
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ENG_GAP: begin
          if (tmr_q == '0) begin
            state_q <= ENG_IDLE;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_stream_ser.sv
module adc_stream_ser
  import adc_ser_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int WORD_W   = 16,
  parameter int GROUP_N  = 8,
  parameter int BUF_W    = 32,
  parameter int HALF_CYC = 4,
  parameter int GAP_CYC  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                pack_mode,
  output logic                sclk,
  output logic                mosi,
  output logic                cs_n,
  output logic                overflow
);

  localparam int FILL_W = $clog2(BUF_W + 1);

  ser_mode_t         mode_act;
  logic              accept, pad_go, pop;
  logic [FILL_W-1:0] pad_len, pop_len, fill, free_bits;
  logic [WORD_W-1:0] buf_top;

  assign accept = smp_valid && (free_bits >= FILL_W'(SAMPLE_W));

  adc_ser_bitbuf #(
    .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .BUF_W(BUF_W), .FILL_W(FILL_W)
  ) u_buf (
    .clk(clk), .rst(rst),
    .push(accept), .push_data(smp_data),
    .pad_go(pad_go), .pad_len(pad_len),
    .pop(pop), .pop_len(pop_len),
    .buf_top(buf_top), .fill(fill), .free_bits(free_bits)
  );

  adc_ser_modectl #(
    .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .GROUP_N(GROUP_N), .FILL_W(FILL_W)
  ) u_mode (
    .clk(clk), .rst(rst),
    .mode_req(pack_mode), .smp_valid(smp_valid), .accept(accept),
    .free_bits(free_bits), .fill_zero(fill == '0),
    .mode_act(mode_act), .pad_go(pad_go), .pad_len(pad_len)
  );

  adc_ser_shifter #(
    .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .HALF_CYC(HALF_CYC),
    .GAP_CYC(GAP_CYC), .FILL_W(FILL_W)
  ) u_shift (
    .clk(clk), .rst(rst),
    .mode_act(mode_act), .fill(fill), .buf_top(buf_top),
    .pop(pop), .pop_len(pop_len),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow <= 1'b0;
    end else if (smp_valid && !accept) begin
      overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_stream_ser_chk.sv
module adc_stream_ser_chk (
  input logic clk,
  input logic rst,
  input logic smp_valid,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic overflow
);

  // R7: bit clock idles low outside a frame
  assert_sclk_low_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R7: frame select never released mid-pulse, and never for just one cycle
  assert_cs_release_clean_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> !sclk);
  assert_cs_gap_held_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> cs_n);

  // R6: data stays put across the rising clock edge
  assert_data_before_clock_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));

  // R9: overflow is sticky and only follows a strobe
  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  assert_overflow_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(smp_valid));

endmodule

bind adc_stream_ser adc_stream_ser_chk u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .sclk(sclk),
  .mosi(mosi), .cs_n(cs_n), .overflow(overflow)
);

// File: tb/test_adc_stream_ser.sv
module test_adc_stream_ser;

  localparam int CLK_PERIOD = 10;
  localparam int GAP_CYC    = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic [9:0] smp_data = '0;
  logic       pack_mode = 1'b0;
  logic       sclk, mosi, cs_n, overflow;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic rx_bits [0:4095];
  int   chunk_len [0:511];
  int   rx_n = 0, chunk_n = 0, cur_len = 0;
  int   bad_setup = 0, bad_idle = 0, gap_run = 0, min_gap = 1000;
  logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_stream_ser #(.GAP_CYC(GAP_CYC)) i_adc_stream_ser (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .pack_mode(pack_mode), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .overflow(overflow)
  );

  // Serial receiver, sampling away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (sclk && !prev_sclk) begin
        if (mosi !== prev_mosi) bad_setup++;
        if (!cs_n && rx_n < 4096) begin
          rx_bits[rx_n] = mosi;
          rx_n++;
          cur_len++;
        end
      end
      if (cs_n && sclk) bad_idle++;
      if (cs_n && !prev_cs) begin
        if (chunk_n < 512) chunk_len[chunk_n] = cur_len;
        chunk_n++;
        cur_len = 0;
        gap_run = 0;
      end
      if (cs_n) gap_run++;
      if (!cs_n && prev_cs && chunk_n > 0 && gap_run < min_gap) min_gap = gap_run;
    end
    prev_sclk = sclk;
    prev_mosi = mosi;
    prev_cs   = cs_n;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [9:0] v);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = v;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  function automatic logic [31:0] grab(input int from, input int len);
    logic [31:0] r = '0;
    for (int i = 0; i < len; i++) r = {r[30:0], rx_bits[from + i]};
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(2);
  endtask

  task automatic t_reset();
    chk("R1", "cs_n after reset", cs_n, 1);
    chk("R1", "sclk after reset", sclk, 0);
    chk("R1", "mosi after reset", mosi, 0);
    chk("R1", "overflow after reset", overflow, 0);
  endtask

  task automatic t_raw();
    logic [9:0] vals [3] = '{10'h2A5, 10'h3FF, 10'h001};
    for (int k = 0; k < 3; k++) begin
      int c0 = chunk_n;
      int b0 = rx_n;
      strobe(vals[k]);
      wait_cyc(189);
      chk("R3", "raw frame done in period", chunk_n - c0, 1);
      chk("R2", "raw frame length", chunk_len[c0], 10);
      chk("R2", "raw frame value", grab(b0, 10), {22'b0, vals[k]});
      wait_cyc(9);
    end
  endtask

  task automatic t_packed();
    logic [79:0] exp_bits;
    int c0, b0, mism;
    pack_mode = 1'b1;
    wait_cyc(20);
    c0 = chunk_n;
    b0 = rx_n;
    for (int k = 0; k < 8; k++) begin
      logic [9:0] v = 10'((k * 157 + 61) ^ (k << 6));
      exp_bits[79 - k*10 -: 10] = v;
      strobe(v);
      wait_cyc(198);
    end
    wait_cyc(400);
    chk("R4", "packed frame count", chunk_n - c0, 5);
    for (int j = 0; j < 5; j++) chk("R4", "packed frame length", chunk_len[c0 + j], 16);
    mism = 0;
    for (int i = 0; i < 80; i++) if (rx_bits[b0 + i] !== exp_bits[79 - i]) mism++;
    chk("R5", "packed bit stream mismatches", mism, 0);
  endtask

  task automatic t_switch();
    logic [9:0] s [3] = '{10'h3C3, 10'h0F0, 10'h2DB};
    logic [31:0] exp_w;
    int c0, b0;
    c0 = chunk_n;
    b0 = rx_n;
    for (int k = 0; k < 3; k++) begin
      strobe(s[k]);
      wait_cyc(198);
    end
    pack_mode = 1'b0;
    wait_cyc(600);
    exp_w = {s[0], s[1], s[2], 2'b00};
    chk("R8", "padded frame count", chunk_n - c0, 2);
    chk("R8", "padded frame length", chunk_len[c0], 16);
    chk("R8", "padded second length", chunk_len[c0 + 1], 16);
    chk("R8", "padded bits", grab(b0, 32), exp_w);
    c0 = chunk_n;
    b0 = rx_n;
    strobe(10'h155);
    wait_cyc(198);
    chk("R8", "raw frame after switch length", chunk_len[c0], 10);
    chk("R8", "raw frame after switch value", grab(b0, 10), 32'h155);
  endtask

  task automatic t_timing();
    chk("R6", "data moved at clock rise", bad_setup, 0);
    chk("R7", "clock high outside frame", bad_idle, 0);
    chk("R7", "minimum gap ok", (min_gap >= GAP_CYC) ? 1 : 0, 1);
    chk("R9", "no overflow under paced traffic", overflow, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    pack_mode = 1'b1;
    wait_cyc(10);
    chk("R9", "overflow clear before burst", overflow, 0);
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      smp_valid = 1'b1;
      smp_data  = 10'(k + 1);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    wait_cyc(5);
    chk("R9", "overflow after burst", overflow, 1);
    wait_cyc(300);
    chk("R9", "overflow stays set", overflow, 1);
    do_reset();
    chk("R1", "overflow cleared by reset", overflow, 0);
    chk("R1", "cs_n idle after reset", cs_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    t_reset();
    t_raw();
    t_packed();
    t_switch();
    t_timing();
    t_overflow();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule